// File: doc/BRIEF.md
# Multimode Debug Counter Register

This block is one register of a debug unit. It is a counter that works in one of three behaviours, selected by a mode input. In cycle-count mode it measures how long the processor ran between two stops. It is cleared when the processor leaves the stopped (debug) state, then counts up each running cycle, and it saturates at the top of its range. In countdown mode it holds a value that the host loaded earlier. That value is not cleared when execution resumes. The counter steps down once per running cycle and issues a one-cycle stop request when it lands on zero. In address-match mode the register holds still and issues a stop request when a fetched program address equals its value. A fourth mode code parks the register.

The host writes the register through a load strobe and data bus, and a write takes effect only while the processor is stopped. In every mode the register is frozen while the processor is stopped, so a value read by the host stays fixed between writes. Entering and leaving the stopped state, and what follows from a request, are handled outside this block.

Top module: `dbgctr_top`

## Requirements
- R1: After reset, `count` is 0000H and `brk_req` is 0.
- R2: With `dbg_mode`=1 and `host_ld`=1 at a clock edge, `count` equals `host_data` after that edge. `host_ld` with `dbg_mode`=0 has no effect on `count`.
- R3: In cycle-count mode (`mode_sel`=0), the first running cycle after a 1-to-0 change of `dbg_mode` clears `count` to 0000H.
- R4: In cycle-count mode, every later running cycle adds one to `count`, and `brk_req` stays 0.
- R5: In cycle-count mode, `count` stops at FFFFH and does not wrap.
- R6: In countdown mode (`mode_sel`=1), leaving debug mode does not clear `count`. Each running cycle with `count` nonzero subtracts one.
- R7: In countdown mode, `brk_req` is 1 for exactly the one cycle after the edge at which `count` steps from 0001H to 0000H. `count` then holds at 0000H with no further request.
- R8: While `dbg_mode`=1 and no load is made, `count` does not change in any mode.
- R9: In address-match mode (`mode_sel`=2), `count` never changes while running. `brk_req` is 1 in the cycle after a running cycle with `pc_fetch`=1 and `pc` equal to `count`.
- R10: No request follows a cycle with `dbg_mode`=1, a cycle without `pc_fetch`, or a fetch whose `pc` differs from `count`.
- R11: With `mode_sel`=3 the register holds its value and `brk_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_mode | input | 1 | 1 while the processor is stopped in debug mode |
| pc | input | 16 | Current program address |
| pc_fetch | input | 1 | 1 on cycles where `pc` is an instruction fetch |
| mode_sel | input | 2 | 0 cycle count, 1 countdown, 2 address match, 3 hold |
| host_ld | input | 1 | Host write strobe for the register |
| host_data | input | 16 | Host write value |
| count | output | 16 | Current register value |
| brk_req | output | 1 | One-cycle stop request |

## Verification
Both outputs are registered. Any input pattern shows its effect exactly one clock edge later: a load, a clear, an increment, a decrement, or a request pulse. The bench drives inputs on the falling edge and samples both outputs 1 ns after the following rising edge. It compares them against a cycle model that holds the previous debug flag and advances once per cycle. A debug exit therefore produces the clear in the first sampled cycle, and the zero-landing request arrives in the same sample as the 0000H value.

// File: rtl/dbgctr_pkg.sv
package dbgctr_pkg;
  typedef enum logic [1:0] {
    MD_CYCLES  = 2'd0,
    MD_DOWN    = 2'd1,
    MD_PCMATCH = 2'd2,
    MD_HOLD    = 2'd3
  } dbgctr_mode_e;
endpackage

// File: rtl/dbgctr_phase.sv
// Tracks the debug flag and marks the first running cycle after a stop.
module dbgctr_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_mode,
  output logic running,
  output logic exit_evt
);
  logic dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_q <= 1'b0;
    else        dbg_q <= dbg_mode;
  end

  assign running  = !dbg_mode;
  assign exit_evt = dbg_q && !dbg_mode;

  // R3: an exit event can only follow a debug cycle
  p_exit_after_dbg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |-> $past(dbg_mode));
endmodule

// File: rtl/dbgctr_next.sv
// Next-value selection for the register in each mode.
module dbgctr_next
  import dbgctr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  dbgctr_mode_e     mode,
  input  logic             running,
  input  logic             exit_evt,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = '0;

  function automatic logic [CNT_W-1:0] sat_up(input logic [CNT_W-1:0] v);
    return (v == TOP) ? TOP : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] floor_down(input logic [CNT_W-1:0] v);
    return (v == ZERO) ? ZERO : v - 1'b1;
  endfunction

  always_comb begin
    nxt = cur;
    if (load_evt) begin
      nxt = load_val;
    end else if (running) begin
      unique case (mode)
        MD_CYCLES:  nxt = exit_evt ? ZERO : sat_up(cur);
        MD_DOWN:    nxt = floor_down(cur);
        MD_PCMATCH: nxt = cur;
        default:    nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/dbgctr_req.sv
// Registered one-cycle stop request.
module dbgctr_req
  import dbgctr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dbgctr_mode_e     mode,
  input  logic             running,
  input  logic             pc_fetch,
  input  logic [CNT_W-1:0] pc,
  input  logic [CNT_W-1:0] cur,
  output logic             brk_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic hit_zero;
  logic hit_pc;
  logic req_d;

  assign hit_zero = running && (mode == MD_DOWN) && (cur == ONE);
  assign hit_pc   = running && (mode == MD_PCMATCH) && pc_fetch && (pc == cur);
  assign req_d    = hit_zero || hit_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= req_d;
  end

  // R10: a stopped cycle is never followed by a request
  p_quiet_in_dbg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !brk_req);
  // R10: a non-fetch cycle in address-match mode gives no request
  p_no_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PCMATCH && !pc_fetch) |=> !brk_req);
  // R11: the hold code never requests
  p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HOLD) |=> !brk_req);
  // R4: cycle-count mode never requests
  p_cycles_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CYCLES) |=> !brk_req);
endmodule

// File: rtl/dbgctr_top.sv
module dbgctr_top
  import dbgctr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_mode,
  input  logic [CNT_W-1:0] pc,
  input  logic             pc_fetch,
  input  logic [1:0]       mode_sel,
  input  logic             host_ld,
  input  logic [CNT_W-1:0] host_data,
  output logic [CNT_W-1:0] count,
  output logic             brk_req
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  dbgctr_mode_e     mode;
  logic             running;
  logic             exit_evt;
  logic             load_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign mode     = dbgctr_mode_e'(mode_sel);
  assign load_evt = dbg_mode && host_ld;

  dbgctr_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_mode (dbg_mode),
    .running  (running),
    .exit_evt (exit_evt)
  );

  dbgctr_next #(.CNT_W(CNT_W)) u_next (
    .mode     (mode),
    .running  (running),
    .exit_evt (exit_evt),
    .load_evt (load_evt),
    .load_val (host_data),
    .cur      (cnt_q),
    .nxt      (cnt_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  dbgctr_req #(.CNT_W(CNT_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .running  (running),
    .pc_fetch (pc_fetch),
    .pc       (pc),
    .cur      (cnt_q),
    .brk_req  (brk_req)
  );

  assign count = cnt_q;

  // R2: a load in debug mode lands on the next edge
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cnt_q == $past(host_data)));
  // R3: exit in cycle-count mode clears the register
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_evt && mode == MD_CYCLES) |=> (cnt_q == '0));
  // R4: running increments below the top
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !exit_evt && mode == MD_CYCLES && cnt_q != TOP)
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R5: saturation at the top
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !exit_evt && mode == MD_CYCLES && cnt_q == TOP) |=> (cnt_q == TOP));
  // R6: countdown steps by one
  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MD_DOWN && cnt_q != '0)
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R7: countdown stays at zero without a repeat request
  p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MD_DOWN && cnt_q == '0) |=> (cnt_q == '0 && !brk_req));
  // R7: a countdown request coincides with a zero value
  p_req_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MD_DOWN) |=> (!brk_req || cnt_q == '0));
  // R8: frozen while stopped without a load
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !host_ld) |=> $stable(cnt_q));
  // R9: address-match mode never alters the register while running
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MD_PCMATCH) |=> $stable(cnt_q));
  // R11: hold code keeps the value while running
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MD_HOLD) |=> $stable(cnt_q));
endmodule

// File: tb/dbgctr_top_bench.sv
`timescale 1ns/1ps
module dbgctr_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b1;
  logic [15:0] pc = '0;
  logic        pc_fetch = 1'b0;
  logic [1:0]  mode_sel = 2'd3;
  logic        host_ld = 1'b0;
  logic [15:0] host_data = '0;
  logic [15:0] count;
  logic        brk_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] m_cnt = '0;
  logic        m_dq = 1'b0;
  logic        m_brk = 1'b0;

  always #5 clk = ~clk;

  dbgctr_top u_dbgctr_top (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .pc(pc), .pc_fetch(pc_fetch),
    .mode_sel(mode_sel), .host_ld(host_ld), .host_data(host_data),
    .count(count), .brk_req(brk_req)
  );

  // Expected register value after one edge, from the requirements
  function automatic logic [15:0] want_cnt(input logic [15:0] c, input logic dq,
      input logic dbg, input logic [1:0] md, input logic ld, input logic [15:0] d);
    if (dbg) return ld ? d : c;
    if (md == 2'd0) begin
      if (dq) return 16'h0000;
      return (c == 16'hFFFF) ? c : c + 16'd1;
    end
    if (md == 2'd1) return (c == 16'h0000) ? c : c - 16'd1;
    return c;
  endfunction

  function automatic logic want_brk(input logic [15:0] c, input logic dbg,
      input logic [1:0] md, input logic f, input logic [15:0] p);
    if (dbg) return 1'b0;
    if (md == 2'd1) return c == 16'h0001;
    if (md == 2'd2) return f && (p == c);
    return 1'b0;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (count !== m_cnt) begin
      errors++;
      $display("FAIL %s count actual=%h expected=%h", tag, count, m_cnt);
    end
    checks++;
    if (brk_req !== m_brk) begin
      errors++;
      $display("FAIL %s brk_req actual=%b expected=%b", tag, brk_req, m_brk);
    end
  endtask

  // Called at a falling edge: drive, step one rising edge, compare
  task automatic step(input string tag, input logic dbg, input logic [1:0] md,
      input logic ld, input logic [15:0] d, input logic f, input logic [15:0] p);
    logic [15:0] nc;
    logic        nb;
    dbg_mode = dbg; mode_sel = md; host_ld = ld; host_data = d; pc_fetch = f; pc = p;
    nc = want_cnt(m_cnt, m_dq, dbg, md, ld, d);
    nb = want_brk(m_cnt, dbg, md, f, p);
    @(posedge clk);
    m_cnt = nc; m_brk = nb; m_dq = dbg;
    #1;
    check(tag);
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 load in debug, ignored when running
    step("R2 load", 1, 2'd3, 1, 16'h1234, 0, 16'h0);
    step("R2 ignored running", 0, 2'd3, 1, 16'hBEEF, 0, 16'h0);
    step("R2 ignored running", 0, 2'd3, 1, 16'h5555, 0, 16'h0);

    // R3 clear on exit, R4 increments, R8 freeze
    step("R3 load", 1, 2'd0, 1, 16'h0055, 0, 16'h0);
    step("R3 clear on exit", 0, 2'd0, 0, 16'h0, 0, 16'h0);
    for (int i = 0; i < 5; i++) step("R4 count up", 0, 2'd0, 0, 16'h0, 1, 16'h4);
    for (int i = 0; i < 3; i++) step("R8 freeze", 1, 2'd0, 0, 16'h0, 0, 16'h0);
    step("R3 clear again", 0, 2'd0, 0, 16'h0, 0, 16'h0);

    // R5 saturation: load near top, leave in hold code, then switch mode while running
    step("R5 load", 1, 2'd3, 1, 16'hFFFD, 0, 16'h0);
    step("R11 hold run", 0, 2'd3, 0, 16'h0, 0, 16'h0);
    for (int i = 0; i < 5; i++) step("R5 saturate", 0, 2'd0, 0, 16'h0, 0, 16'h0);

    // R6 R7 countdown
    step("R6 load", 1, 2'd1, 1, 16'h0003, 0, 16'h0);
    for (int i = 0; i < 6; i++) step("R7 countdown to zero", 0, 2'd1, 0, 16'h0, 0, 16'h0);
    step("R6 load", 1, 2'd1, 1, 16'h000A, 0, 16'h0);
    for (int i = 0; i < 3; i++) step("R6 no clear on exit", 0, 2'd1, 0, 16'h0, 0, 16'h0);
    for (int i = 0; i < 3; i++) step("R8 freeze countdown", 1, 2'd1, 0, 16'h0, 0, 16'h0);
    for (int i = 0; i < 9; i++) step("R7 resume", 0, 2'd1, 0, 16'h0, 0, 16'h0);

    // R9 R10 address match
    step("R9 load", 1, 2'd2, 1, 16'h0400, 0, 16'h0);
    step("R10 mismatch", 0, 2'd2, 0, 16'h0, 1, 16'h03FE);
    step("R10 no fetch", 0, 2'd2, 0, 16'h0, 0, 16'h0400);
    step("R9 match", 0, 2'd2, 0, 16'h0, 1, 16'h0400);
    step("R10 mismatch", 0, 2'd2, 0, 16'h0, 1, 16'h0402);
    step("R9 match", 0, 2'd2, 0, 16'h0, 1, 16'h0400);
    step("R10 in debug", 1, 2'd2, 0, 16'h0, 1, 16'h0400);
    step("R9 match", 0, 2'd2, 0, 16'h0, 1, 16'h0400);

    // R11 hold code
    for (int i = 0; i < 3; i++) step("R11 hold", 0, 2'd3, 0, 16'h0, 1, 16'h0400);

    // Mixed random run (R2 R4 R6 R9 R10)
    for (int i = 0; i < 3000; i++) begin
      logic dbg;
      logic [1:0] md;
      logic [15:0] d;
      logic [15:0] p;
      dbg = ($urandom % 4) == 0;
      md  = 2'($urandom % 4);
      d   = 16'($urandom % 12);
      p   = ($urandom % 2) ? m_cnt : 16'($urandom % 12);
      step("R2 R4 R6 R9 R10 random", dbg, md, 1'($urandom % 2), d, 1'($urandom % 2), p);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule